// File: doc/BRIEF.md
# Chainable Four-Channel Interval Counter Bank

This block holds four independent 16-bit up-counters that all run from one system clock. Each counter advances either on a tick from its own power-of-two clock divider or, when chained, on every wrap of the counter one position below it. Chained counters act as one wider counter, for example a 32-bit or 64-bit count built from 16-bit pieces.

Software reaches each counter through two registers on a simple memory-mapped port. The first is a value register. Writing it stores a restart value, and reading it returns the live count. The second is a mode register, which holds the divider choice, the chain flag, the interrupt flag and the run flag. When a counter wraps past its top value, it restarts from its stored restart value. If its interrupt flag is set, it also raises a single-cycle pulse on its own interrupt line.

Top module: `tmr_bank`

## Requirements
- R1: After reset every count, every restart value and every mode register reads 0, and all four interrupt lines are low.
- R2: Address bits [2:1] select the counter and address bit 0 selects the register: 0 is the value register, 1 is the mode register. The mode register fields are: bits [1:0] divider select, bit 2 chain, bit 3 interrupt enable, bit 4 run. Reading the mode register returns those five bits with zeros above them.
- R3: With chain off, a running counter advances by one every 1, 64, 256 or 1024 clock edges, for divider select 0, 1, 2 or 3.
- R4: When a mode write changes run from 0 to 1, the count takes the restart value at that edge and the divider restarts its phase. The first advance therefore comes exactly one divider period later.
- R5: An advance from 0xFFFF loads the restart value instead of 0.
- R6: A counter other than counter 0 with chain and run set advances on exactly the edges at which the counter below it wraps, and its divider select has no effect.
- R7: The chain flag of counter 0 has no effect; counter 0 keeps counting from its divider.
- R8: Each wrap of a counter whose interrupt enable is set drives its interrupt line high for the one cycle after the wrap edge. With interrupt enable clear, a wrap leaves the line low.
- R9: A counter with run clear holds its count. Writing a value register changes only the restart value and never the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address: counter index in [2:1], register select in [0] |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| irq_pulse | output | 4 | Per-counter single-cycle wrap interrupt |

## Verification
The assertions assume three things about the inputs: the write strobe is a clean synchronous level, each write targets a single register, and a counter is only started from the stopped state if it is meant to reload. The stimulus respects this. It stops a counter before it rewrites that counter's restart value or divider, and it never writes the value register of a counter on the edge at which that counter wraps. Random runs pick the counter, the divider, the restart value (sometimes close to 0xFFFF so that wraps occur) and the wait length from a fixed seed. Directed cases cover chaining, counter 0's ignored chain flag and the interrupt pulse.

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int NT = 4,
  parameter int CW = 16,
  parameter int AW = 3,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NT-1:0] irq_pulse
);
  localparam int IW = AW - 1;
  localparam int MW = 5;

  logic [CW-1:0] cnt_q [NT];
  logic [CW-1:0] rld_q [NT];
  logic [MW-1:0] ctl_q [NT];
  logic [PW-1:0] pre_q [NT];

  logic [NT-1:0] ovf, ld, run_v, ien_v, chn_v;

  wire [IW-1:0] sel_t  = bus_addr[AW-1:1];
  wire          is_ctl = bus_addr[0];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    wire hit_me = (sel_t == IW'(i));
    wire wr_d   = bus_we && hit_me && !is_ctl;
    wire wr_c   = bus_we && hit_me && is_ctl;
    wire run    = ctl_q[i][4];
    logic [PW-1:0] lim;
    logic tick_l, ovf_l, chn_l;

    always_comb begin
      case (ctl_q[i][1:0])
        2'd0:    lim = PW'(0);
        2'd1:    lim = PW'(63);
        2'd2:    lim = PW'(255);
        default: lim = PW'(1023);
      endcase
    end

    wire pre_hit = (pre_q[i] == lim);

    if (i == 0) begin : g_head
      assign chn_l  = 1'b0;
      assign tick_l = run && pre_hit;
    end else begin : g_link
      assign chn_l  = ctl_q[i][2];
      assign tick_l = run && (chn_l ? g_tmr[i-1].ovf_l : pre_hit);
    end

    assign ovf_l    = tick_l && (cnt_q[i] == '1);
    assign ovf[i]   = ovf_l;
    assign ld[i]    = wr_c && bus_wdata[4] && !run;
    assign run_v[i] = run;
    assign ien_v[i] = ctl_q[i][3];
    assign chn_v[i] = chn_l;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        rld_q[i] <= '0;
        ctl_q[i] <= '0;
        pre_q[i] <= '0;
      end else begin
        if (wr_d) rld_q[i] <= bus_wdata;
        if (wr_c) ctl_q[i] <= bus_wdata[MW-1:0];
        if (ld[i]) begin
          cnt_q[i] <= rld_q[i];
          pre_q[i] <= '0;
        end else begin
          if (tick_l) cnt_q[i] <= ovf_l ? rld_q[i] : cnt_q[i] + 1'b1;
          if (run && !chn_l) pre_q[i] <= pre_hit ? '0 : pre_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= '0;
    else        irq_pulse <= ovf & ien_v;
  end

  assign bus_rdata = is_ctl ? CW'(ctl_q[sel_t]) : cnt_q[sel_t];

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NT = 4,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NT-1:0] irq_pulse,
  input logic [NT-1:0] ovf,
  input logic [NT-1:0] ld,
  input logic [NT-1:0] run_v,
  input logic [NT-1:0] ien_v,
  input logic [NT-1:0] chn_v,
  input logic [CW-1:0] cnt_q [NT],
  input logic [CW-1:0] rld_q [NT]
);
  for (genvar i = 0; i < NT; i++) begin : g_chk
    assert_irq_after_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |-> $past(ovf[i] && ien_v[i]));
    assert_wrap_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[i] && ien_v[i]) |=> irq_pulse[i]);
    assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[i] |=> (cnt_q[i] == $past(rld_q[i])));
    assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ld[i] |=> (cnt_q[i] == $past(rld_q[i])));
    assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[i] && !ld[i]) |=> $stable(cnt_q[i]));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[i] && !ovf[i]) |=> (cnt_q[i] == $past(cnt_q[i]) || cnt_q[i] == $past(cnt_q[i]) + 1'b1));
    if (i > 0) begin : g_up
      assert_chain_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_v[i] && chn_v[i] && !ovf[i-1]) |=> $stable(cnt_q[i]));
    end
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NT(NT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .ovf(ovf), .ld(ld),
  .run_v(run_v), .ien_v(ien_v), .chn_v(chn_v), .cnt_q(cnt_q), .rld_q(rld_q)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_pulse;

  int checks = 0;
  int errors = 0;

  tmr_bank u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int div_of(input int s);
    case (s)
      0: return 1;
      1: return 64;
      2: return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic logic [15:0] exp_cnt(input logic [15:0] rl, input int dv, input int k);
    int inc, per;
    inc = k / dv;
    per = 65536 - int'(rl);
    return 16'(int'(rl) + (inc % per));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int t, input bit ctl, input logic [15:0] d);
    @(negedge clk);
    bus_addr = {2'(t), ctl};
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int t, input bit ctl, output logic [15:0] d);
    bus_addr = {2'(t), ctl};
    #1;
    d = bus_rdata;
  endtask

  task automatic stop_all();
    for (int t = 0; t < 4; t++) wr(t, 1'b1, 16'h0000);
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v, v2;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int t = 0; t < 4; t++) begin
      rd(t, 1'b0, v); chk("R1 count", v, 0);
      rd(t, 1'b1, v); chk("R1 mode", v, 0);
    end
    chk("R1 irq", irq_pulse, 0);

    // R2 mode readback; R9 value write leaves live count
    wr(2, 1'b1, 16'hFFEB);
    rd(2, 1'b1, v); chk("R2 mode field readback", v, 16'h000B);
    wr(2, 1'b0, 16'h1234);
    rd(2, 1'b0, v); chk("R9 value write keeps count", v, 16'h0000);
    wr(2, 1'b1, 16'h0000);

    // R3 R4 R5 random divider runs
    for (int it = 0; it < 30; it++) begin
      int t, s, k;
      logic [15:0] rl;
      t = int'($urandom_range(0, 3));
      s = int'($urandom_range(0, 3));
      k = int'($urandom_range(0, 2500));
      rl = ($urandom_range(0, 1) == 1) ? 16'(16'hFFFF - $urandom_range(0, 200))
                                       : 16'($urandom);
      wr(t, 1'b1, 16'h0000);
      wr(t, 1'b0, rl);
      wr(t, 1'b1, 16'h0010 | 16'(s));
      wait_edges(k);
      rd(t, 1'b0, v);
      chk("R3 R4 R5 divided count", v, exp_cnt(rl, div_of(s), k));
      wr(t, 1'b1, 16'h0000);
      rd(t, 1'b0, v);
      wait_edges(int'($urandom_range(5, 60)));
      rd(t, 1'b0, v2);
      chk("R9 stopped hold", v2, v);
    end

    // R4 start with divide 64: no advance before 64 edges, one at 64
    stop_all();
    wr(3, 1'b0, 16'h0100);
    wr(3, 1'b1, 16'h0011);
    wait_edges(63);
    rd(3, 1'b0, v); chk("R4 no advance before period", v, 16'h0100);
    wait_edges(1);
    rd(3, 1'b0, v); chk("R4 first advance at period", v, 16'h0101);

    // R8 interrupt pulse
    stop_all();
    wr(1, 1'b0, 16'hFFFE);
    wr(1, 1'b1, 16'h0018);
    wait_edges(1);
    chk("R8 no irq before wrap", irq_pulse[1], 0);
    wait_edges(1);
    chk("R8 irq after wrap", irq_pulse[1], 1);
    rd(1, 1'b0, v); chk("R5 wrap to restart", v, 16'hFFFE);
    wait_edges(1);
    chk("R8 irq one cycle", irq_pulse[1], 0);
    wait_edges(1);
    chk("R8 irq next wrap", irq_pulse[1], 1);
    wr(1, 1'b1, 16'h0000);
    wr(1, 1'b1, 16'h0010);
    begin
      int seen = 0;
      for (int c = 0; c < 8; c++) begin
        wait_edges(1);
        if (irq_pulse[1]) seen++;
      end
      chk("R8 irq masked", seen, 0);
    end

    // R6 chaining
    stop_all();
    wr(0, 1'b0, 16'hFFF0);
    wr(1, 1'b0, 16'h0010);
    wr(2, 1'b0, 16'h0500);
    wr(1, 1'b1, 16'h0017);
    wr(2, 1'b1, 16'h0014);
    wr(0, 1'b1, 16'h0010);
    wait_edges(100);
    rd(0, 1'b0, v); chk("R6 low counter", v, 16'hFFF4);
    rd(1, 1'b0, v); chk("R6 chained counter", v, 16'h0016);
    rd(2, 1'b0, v); chk("R6 second link idle", v, 16'h0500);
    wr(1, 1'b0, 16'hFFFF);
    wr(1, 1'b1, 16'h0000);
    wr(1, 1'b1, 16'h0014);
    wr(0, 1'b1, 16'h0000);
    wr(0, 1'b1, 16'h0010);
    wait_edges(32);
    rd(1, 1'b0, v); chk("R6 chained wrap", v, 16'hFFFF);
    rd(2, 1'b0, v); chk("R6 carry into third", v, 16'h0502);

    // R7 counter 0 ignores chain
    stop_all();
    wr(0, 1'b0, 16'h0000);
    wr(0, 1'b1, 16'h0014);
    wait_edges(37);
    rd(0, 1'b0, v); chk("R7 chain flag ignored on counter 0", v, 16'd37);

    stop_all();
    summary();
  end
endmodule